// File: doc/BRIEF.md
# Page Write Buffer Engine

This block sits behind the protocol front end of a paged serial memory. A front end opens a session by presenting a starting byte address. It then streams data bytes, and it closes the session with either a commit strobe or an abort strobe. The engine latches the page part of the address and keeps a running offset inside that page. It stores each byte in a small page buffer and marks the offset as loaded in a per-offset mask.

On a commit that carries at least one loaded byte, the engine raises busy for a programmable number of clock cycles. When that interval ends, it writes the loaded bytes of the page into the storage array in one step. Bytes that were not loaded keep their previous contents. Write protection is sampled when the first data byte of a session arrives, and a protected session never touches the array. A separate registered read port gives access to any byte of the array at any time.

Top module: `pwb_engine`

## Requirements
- R1: After reset, busy_o is low and every array location reads back as 8'hFF.
- R2: rd_data_o presents the byte stored at rd_addr_i one clock after rd_addr_i is applied. This holds in every state of the engine.
- R3: start_i takes the session page from addr_i[12:5] and the first offset from addr_i[4:0]. addr_i[15:13] have no effect on where bytes land.
- R4: Each accepted load_i advances the offset by one. After offset 31 the offset returns to offset 0 of the same page, and the next page is never touched.
- R5: When a session loads an offset a second time, the later byte replaces the earlier one.
- R6: A commit writes only the offsets loaded in that session. Every other byte of the page keeps its previous value, and a byte that was never written still reads 8'hFF.
- R7: A commit with at least one loaded byte raises busy_o on the next clock edge and holds it for exactly WR_CYCLES cycles. The array changes only on the edge where busy_o falls, so reads during busy return the old data.
- R8: While busy_o is high, start_i, load_i, commit_i and abort_i are ignored.
- R9: An abort, or a commit of a session with no loaded bytes, leaves busy_o low and the array unchanged.
- R10: If wp_i is high when the first data byte of a session arrives, the whole session is rejected. Its commit leaves busy_o low and the array unchanged. If wp_i rises only after the first byte, the session is not rejected.
- R11: A load_i or commit_i outside an open session (after a commit or abort, with no new start_i) has no effect.
- R12: When several strobes arrive in one cycle, the engine acts on only one of them. Abort has the highest priority, then commit, then start, then load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Open a session at addr_i |
| addr_i | input | 16 | Starting byte address field; only the low 13 bits are used |
| load_i | input | 1 | Strobe carrying one data byte |
| data_i | input | 8 | Data byte for load_i |
| wp_i | input | 1 | Write protect level, sampled at the first byte of a session |
| commit_i | input | 1 | Close the session and start the timed write |
| abort_i | input | 1 | Close the session and discard the buffer |
| busy_o | output | 1 | High while the internal write cycle runs |
| rd_addr_i | input | 13 | Read address |
| rd_data_o | output | 8 | Registered read data |

## Verification
The bench keeps the default array geometry of 8192 bytes in 32-byte pages, so it exercises the real page boundary and the real unused top address bits. It sets WR_CYCLES to 12 in place of the large default. With that value the exact length of busy can be counted cycle by cycle. A read that lands inside the busy window can be checked for old data. A full overrun of a 32-byte page, plus write-protect and ignored-strobe cases, all fit in a short run.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // One decoded action per cycle, already prioritised by the top.
  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_ABORT  = 3'd1,
    ACT_COMMIT = 3'd2,
    ACT_START  = 3'd3,
    ACT_LOAD   = 3'd4
  } pwb_act_e;
endpackage

// File: rtl/pwb_fill.sv
module pwb_fill
  import pwb_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PAGE_AW = 5,
  parameter int unsigned ROW_AW  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  pwb_act_e                          act,
  input  logic [ROW_AW-1:0]                 st_row,
  input  logic [PAGE_AW-1:0]                st_off,
  input  logic [DATA_W-1:0]                 ld_data,
  input  logic                              wp,
  output logic [ROW_AW-1:0]                 row_o,
  output logic [(1<<PAGE_AW)*DATA_W-1:0]    buf_o,
  output logic [(1<<PAGE_AW)-1:0]           mask_o,
  output logic                              fire_o,
  output logic                              rej_o
);
  localparam int unsigned NB = 1 << PAGE_AW;

  logic                 open_q, open_d;
  logic                 rej_q, rej_d;
  logic [PAGE_AW-1:0]   off_q, off_d;
  logic [ROW_AW-1:0]    row_q, row_d;
  logic [NB-1:0]        mask_q, mask_d;
  logic                 wr_slot;
  logic [DATA_W-1:0]    slot_q [NB];

  always_comb begin
    open_d  = open_q;
    rej_d   = rej_q;
    off_d   = off_q;
    row_d   = row_q;
    mask_d  = mask_q;
    wr_slot = 1'b0;
    unique case (act)
      ACT_ABORT, ACT_COMMIT: open_d = 1'b0;
      ACT_START: begin
        open_d = 1'b1;
        rej_d  = 1'b0;
        mask_d = '0;
        row_d  = st_row;
        off_d  = st_off;
      end
      ACT_LOAD: begin
        if (open_q && !rej_q) begin
          if (mask_q == '0 && wp) begin
            rej_d = 1'b1;
          end else begin
            wr_slot        = 1'b1;
            mask_d[off_q]  = 1'b1;
            off_d          = off_q + 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign fire_o = (act == ACT_COMMIT) && open_q && !rej_q && (mask_q != '0);
  assign rej_o  = rej_q;
  assign row_o  = row_q;
  assign mask_o = mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rej_q  <= 1'b0;
      off_q  <= '0;
      row_q  <= '0;
      mask_q <= '0;
    end else begin
      open_q <= open_d;
      rej_q  <= rej_d;
      off_q  <= off_d;
      row_q  <= row_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_slot) slot_q[off_q] <= ld_data;
  end

  for (genvar g = 0; g < NB; g++) begin : g_flat
    assign buf_o[g*DATA_W +: DATA_W] = slot_q[g];
  end
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int unsigned WR_CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(WR_CYCLES + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (done_o) busy_d = 1'b0;
      else        cnt_d  = cnt_q - 1'b1;
    end else if (fire) begin
      busy_d = 1'b1;
      cnt_d  = CW'(WR_CYCLES - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned PAGE_AW = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-PAGE_AW-1:0]         wr_row,
  input  logic [(1<<PAGE_AW)*DATA_W-1:0]    wr_data,
  input  logic [(1<<PAGE_AW)-1:0]           wr_mask,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [DATA_W-1:0]                 rd_data
);
  localparam int unsigned NB     = 1 << PAGE_AW;
  localparam int unsigned ROW_AW = ADDR_W - PAGE_AW;
  localparam int unsigned ROWS   = 1 << ROW_AW;
  localparam int unsigned ROW_W  = NB * DATA_W;

  // A row that was never written is still erased; prog_q tracks that.
  logic [ROWS-1:0]    prog_q, prog_d;
  logic [ROW_W-1:0]   mem_q [ROWS];
  logic [ROW_W-1:0]   row_old, row_new;
  logic [ROW_AW-1:0]  rd_row;
  logic [PAGE_AW-1:0] rd_off;
  logic [DATA_W-1:0]  rd_d, rd_q;

  assign row_old = mem_q[wr_row];

  for (genvar g = 0; g < NB; g++) begin : g_merge
    assign row_new[g*DATA_W +: DATA_W] =
      wr_mask[g]     ? wr_data[g*DATA_W +: DATA_W] :
      prog_q[wr_row] ? row_old[g*DATA_W +: DATA_W] : {DATA_W{1'b1}};
  end

  assign rd_row = rd_addr[ADDR_W-1:PAGE_AW];
  assign rd_off = rd_addr[PAGE_AW-1:0];

  always_comb begin
    prog_d = prog_q;
    if (wr_en) prog_d[wr_row] = 1'b1;
    rd_d = prog_q[rd_row] ? mem_q[rd_row][rd_off*DATA_W +: DATA_W] : {DATA_W{1'b1}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
      rd_q   <= '1;
    end else begin
      prog_q <= prog_d;
      rd_q   <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_row] <= row_new;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/pwb_engine.sv
module pwb_engine
  import pwb_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned FIELD_W   = 16,
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned PAGE_AW   = 5,
  parameter int unsigned WR_CYCLES = 625000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [FIELD_W-1:0]  addr_i,
  input  logic                load_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                wp_i,
  input  logic                commit_i,
  input  logic                abort_i,
  output logic                busy_o,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o
);
  localparam int unsigned NB     = 1 << PAGE_AW;
  localparam int unsigned ROW_AW = ADDR_W - PAGE_AW;

  logic                   rst_s, rst_m;
  pwb_act_e               act;
  logic [ROW_AW-1:0]      row_w;
  logic [NB*DATA_W-1:0]   buf_w;
  logic [NB-1:0]          mask_w;
  logic                   fire_w, rej_w, wr_en_w, busy_w;
  logic                   unused_hi;

  assign unused_hi = ^addr_i[FIELD_W-1:ADDR_W];

  // Reset asserts at once, releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  always_comb begin
    act = ACT_NONE;
    if (!busy_w) begin
      if      (abort_i)  act = ACT_ABORT;
      else if (commit_i) act = ACT_COMMIT;
      else if (start_i)  act = ACT_START;
      else if (load_i)   act = ACT_LOAD;
    end
  end

  pwb_fill #(.DATA_W(DATA_W), .PAGE_AW(PAGE_AW), .ROW_AW(ROW_AW)) fill_i (
    .clk(clk), .rst_n(rst_s), .act(act),
    .st_row(addr_i[ADDR_W-1:PAGE_AW]), .st_off(addr_i[PAGE_AW-1:0]),
    .ld_data(data_i), .wp(wp_i),
    .row_o(row_w), .buf_o(buf_w), .mask_o(mask_w), .fire_o(fire_w), .rej_o(rej_w)
  );

  pwb_timer #(.WR_CYCLES(WR_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_s), .fire(fire_w), .busy_o(busy_w), .done_o(wr_en_w)
  );

  pwb_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) array_i (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en_w), .wr_row(row_w),
    .wr_data(buf_w), .wr_mask(mask_w), .rd_addr(rd_addr_i), .rd_data(rd_data_o)
  );

  assign busy_o = busy_w;
endmodule

// File: rtl/pwb_engine_chk.sv
module pwb_engine_chk #(
  parameter int unsigned WR_CYCLES = 625000
) (
  input logic clk,
  input logic rst_n,
  input logic commit_i,
  input logic abort_i,
  input logic busy_o,
  input logic arr_we,
  input logic sess_rej
);
  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  // R7: busy lasts exactly WR_CYCLES cycles
  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_len == WR_CYCLES));

  // R7: busy only rises right after a commit strobe
  a_r7_rise_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(commit_i));

  // R7: array write happens inside busy, on its last cycle
  a_r7_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy_o);
  a_r7_we_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !busy_o);

  // R9: abort never starts a write cycle
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !busy_o) |=> !busy_o);

  // R10: a rejected session never starts a write cycle
  a_r10_rejected_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !busy_o && sess_rej) |=> !busy_o);
endmodule

bind pwb_engine pwb_engine_chk #(.WR_CYCLES(WR_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_s), .commit_i(commit_i), .abort_i(abort_i),
  .busy_o(busy_w), .arr_we(wr_en_w), .sess_rej(rej_w)
);

// File: tb/pwb_engine_tb.sv
module pwb_engine_tb_top;
  localparam int unsigned WRC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, load_i = 1'b0, wp_i = 1'b0;
  logic        commit_i = 1'b0, abort_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [12:0] rd_addr_i = '0;
  logic        busy_o;
  logic [7:0]  rd_data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pwb_engine #(.WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .load_i(load_i), .data_i(data_i), .wp_i(wp_i), .commit_i(commit_i),
    .abort_i(abort_i), .busy_o(busy_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  // {address field, data, expected array address}
  localparam logic [36:0] VEC [5] = '{
    {16'h0000, 8'h11, 13'h0000},
    {16'h1FFF, 8'h22, 13'h1FFF},
    {16'hE005, 8'h33, 13'h0005},
    {16'h2040, 8'h44, 13'h0040},
    {16'hA123, 8'h55, 13'h0123}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [15:0] a);
    @(negedge clk); start_i = 1'b1; addr_i = a;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic do_load(input logic [7:0] d);
    @(negedge clk); load_i = 1'b1; data_i = d;
    @(negedge clk); load_i = 1'b0;
  endtask

  task automatic do_commit();
    @(negedge clk); commit_i = 1'b1;
    @(negedge clk); commit_i = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk); abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] v);
    @(negedge clk); rd_addr_i = a;
    @(negedge clk); v = rd_data_o;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 busy after reset", busy_o, 0);
    rd(13'h0000, v); chk("R1 erased 0000", v, 8'hFF);
    rd(13'h1FFF, v); chk("R1 erased 1FFF", v, 8'hFF);
    rd(13'h0A5A, v); chk("R1 erased 0A5A", v, 8'hFF);

    // R2 R3: table of single-byte sessions
    for (int i = 0; i < 5; i++) begin
      do_start(VEC[i][36:21]);
      do_load(VEC[i][20:13]);
      do_commit();
      wait_idle();
      rd(VEC[i][12:0], v);
      chk("R2/R3 table read", v, {24'h0, VEC[i][20:13]});
    end
    rd(13'h0001, v); chk("R6 unloaded stays FF", v, 8'hFF);
    rd(13'h0000, v); chk("R6 earlier byte kept", v, 8'h11);
    rd(13'h0005, v); chk("R3 top bits ignored", v, 8'h33);

    // R4: wrap inside page
    do_start(16'h07FE);
    do_load(8'hA0); do_load(8'hA1); do_load(8'hA2); do_load(8'hA3);
    do_commit(); wait_idle();
    rd(13'h07FE, v); chk("R4 offset 30", v, 8'hA0);
    rd(13'h07FF, v); chk("R4 offset 31", v, 8'hA1);
    rd(13'h07E0, v); chk("R4 wrapped offset 0", v, 8'hA2);
    rd(13'h07E1, v); chk("R4 wrapped offset 1", v, 8'hA3);
    rd(13'h0800, v); chk("R4 next page untouched", v, 8'hFF);

    // R5: overrun of a page, later bytes replace earlier
    do_start(16'h0100);
    for (int i = 0; i < 34; i++) do_load(8'(8'h40 + i));
    do_commit(); wait_idle();
    rd(13'h0100, v); chk("R5 offset 0 replaced", v, 8'h60);
    rd(13'h0101, v); chk("R5 offset 1 replaced", v, 8'h61);
    rd(13'h0102, v); chk("R5 offset 2 kept", v, 8'h42);
    rd(13'h011F, v); chk("R5 offset 31 kept", v, 8'h5F);

    // R7: busy length
    do_start(16'h0200); do_load(8'h77); do_commit();
    chk("R7 busy rises after commit", busy_o, 1);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    chk("R7 busy length", n, WRC);
    // R7: old data visible during busy
    do_start(16'h0220); do_load(8'h78); do_commit();
    rd(13'h0220, v);
    chk("R7 still busy", busy_o, 1);
    chk("R7 old data during busy", v, 8'hFF);
    wait_idle();
    rd(13'h0220, v); chk("R7 new data after busy", v, 8'h78);

    // R8: strobes ignored during busy
    do_start(16'h0300); do_load(8'h10); do_commit();
    do_start(16'h0340); do_load(8'h99); do_commit(); do_abort();
    chk("R8 still busy", busy_o, 1);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R8 no second cycle", busy_o, 0);
    rd(13'h0340, v); chk("R8 ignored load", v, 8'hFF);
    rd(13'h0300, v); chk("R8 first session written", v, 8'h10);

    // R11: no open session
    do_load(8'h55); do_commit();
    chk("R11 commit without session", busy_o, 0);
    rd(13'h0301, v); chk("R11 load without session", v, 8'hFF);

    // R9: abort and empty commit
    do_start(16'h0400); do_load(8'hAB); do_abort();
    chk("R9 abort no busy", busy_o, 0);
    do_commit();
    chk("R9 commit after abort", busy_o, 0);
    rd(13'h0400, v); chk("R9 aborted byte absent", v, 8'hFF);
    do_start(16'h0420); do_commit();
    chk("R9 empty commit no busy", busy_o, 0);

    // R10: write protection at first byte
    do_start(16'h0500);
    wp_i = 1'b1; do_load(8'hCD); wp_i = 1'b0; do_load(8'hCE);
    do_commit();
    chk("R10 rejected no busy", busy_o, 0);
    rd(13'h0500, v); chk("R10 array unchanged 0500", v, 8'hFF);
    rd(13'h0501, v); chk("R10 array unchanged 0501", v, 8'hFF);
    do_start(16'h0520);
    do_load(8'h01); wp_i = 1'b1; do_load(8'h02); wp_i = 1'b0;
    do_commit();
    chk("R10 late wp accepted", busy_o, 1);
    wait_idle();
    rd(13'h0521, v); chk("R10 late wp data", v, 8'h02);

    // R12: priority, abort beats commit, commit beats load
    do_start(16'h0600); do_load(8'h61);
    @(negedge clk); abort_i = 1'b1; commit_i = 1'b1;
    @(negedge clk); abort_i = 1'b0; commit_i = 1'b0;
    chk("R12 abort over commit", busy_o, 0);
    do_start(16'h0640); do_load(8'h62);
    @(negedge clk); commit_i = 1'b1; load_i = 1'b1; data_i = 8'h63;
    @(negedge clk); commit_i = 1'b0; load_i = 1'b0;
    chk("R12 commit taken", busy_o, 1);
    wait_idle();
    rd(13'h0641, v); chk("R12 load dropped", v, 8'hFF);
    rd(13'h0640, v); chk("R12 committed byte", v, 8'h62);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule